// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

This block is a watchdog peripheral behind a plain word-addressed register port. An up-counter advances on a slow tick enable, either on every tick or once per 2^k ticks through an optional divider. Software picks a start value so that the distance to the all-ones wrap sets the timeout. If software does not re-arm the counter in time, the counter wraps. The block then raises a one-cycle reset pulse toward the system, latches an overflow event and starts again from the start value.

Starting and halting the counter each need two key words written in a set order to one register. This guards against a stray write that would switch the watchdog off. Key and re-arm writes are posted. Each sets a busy flag that software polls, and the write acts only when that flag drops. Re-arming happens when software writes the re-arm register with a value that differs from the one it holds. The block also has a delay-match event, interrupt enables and a self-clearing soft reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, address 0 reads the constant 0x00010A03, all other registers read 0, and `irq` and `wdog_rst` are low.
- R2: Writing 0x0000BBBB and then 0x00004444 to the key register (address 6) makes the counter (address 4) run.
- R3: Writing 0x0000AAAA and then 0x00005555 to the key register halts the counter, and it keeps its value.
- R4: After a first key, any other word returns the key sequence to idle. A second key with no first key before it has no effect.
- R5: A write to the key register or the re-arm register (address 5) sets pending bit 0 or bit 1 of address 7 for exactly 3 cycles. The write takes effect on the edge where the bit clears. A write to the same register while its bit is set is dropped.
- R6: While running, the counter steps on each `tick_en` when control bit 0 (address 2) is 0. When that bit is 1, it steps once per 2^P ticks, where P is control bits 3:1.
- R7: Writing the re-arm register with a value different from its current one loads the counter from the start-value register (address 3) and restarts the divider. Writing the same value has no effect.
- R8: A step taken at count 0xFFFFFFFF reloads the start value, pulses `wdog_rst` high for one cycle and sets status bit 0 (address 10).
- R9: A step that brings the counter to the delay register value (address 8) sets status bit 1.
- R10: Writing 1s to address 9 sets the interrupt enables. Status bits clear when written with 1, but a new event in the same cycle wins. `irq` is high exactly when an enabled status bit is set.
- R11: Writing 1 to bit 0 of address 1 makes that bit read 1 for one cycle. Every register then returns to its reset value and the bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow time-base enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt from enabled status bits |
| wdog_rst | output | 1 | One-cycle system reset pulse on wrap |

## Verification
The bench goes after the key sequence in three ways: a lone second key, a first key followed by a wrong word, and a second key sent while the first is still pending. A design that arms on any second key, or that accepts a write during the busy window, would start counting when it should not. It also writes the re-arm register with an unchanged value, because a design that reloads on every write would be caught by the frozen count. The bench clears the overflow status while the delay status stays set, and uses a divide-by-4 setting with a tick-per-cycle base. Off-by-one errors in the divider, or in the pending count, show up as count mismatches.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_REV  = 4'd0;
    localparam logic [ADDR_W-1:0] A_SYS  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd2;
    localparam logic [ADDR_W-1:0] A_LOAD = 4'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'd4;
    localparam logic [ADDR_W-1:0] A_TRIG = 4'd5;
    localparam logic [ADDR_W-1:0] A_KEY  = 4'd6;
    localparam logic [ADDR_W-1:0] A_PEND = 4'd7;
    localparam logic [ADDR_W-1:0] A_DLY  = 4'd8;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'd9;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd10;

    localparam logic [DATA_W-1:0] KEY_GO1   = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_GO2   = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_HALT1 = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_HALT2 = 32'h0000_5555;

    // posted channel indices, also their bit in the pending register
    localparam int CH_KEY  = 0;
    localparam int CH_TRIG = 1;
    localparam int N_POST  = 2;

    // status / enable bit positions
    localparam int EV_OVF = 0;
    localparam int EV_DLY = 1;

    typedef enum logic [1:0] {
        KS_IDLE     = 2'd0,
        KS_ARM_GO   = 2'd1,
        KS_ARM_HALT = 2'd2
    } keyst_e;
endpackage

// File: rtl/kwd_posted.sv
`timescale 1ns/1ps
module kwd_posted #(
    parameter int DW   = 32,
    parameter int HOLD = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] data_i,
    output logic          busy_o,
    output logic          fire_o,
    output logic [DW-1:0] data_o
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [DW-1:0] dat_d, dat_q;

    always_comb begin
        cnt_d = cnt_q;
        dat_d = dat_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else if (wr_i) begin
            cnt_d = CW'(HOLD);
            dat_d = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dat_q <= '0;
        end else if (sclr_i) begin
            cnt_q <= '0;
            dat_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            dat_q <= dat_d;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign fire_o = (cnt_q == CW'(1));
    assign data_o = dat_q;

    // R5
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_i && !sclr_i) |=> $stable(data_o));

    // R5
    fire_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !busy_o);
endmodule

// File: rtl/kwd_keyseq.sv
`timescale 1ns/1ps
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclr_i,
    input  logic              fire_i,
    input  logic [DATA_W-1:0] key_i,
    output logic              run_o
);
    keyst_e st_d, st_q;
    logic   run_d, run_q;

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        if (fire_i) begin
            case (st_q)
                KS_IDLE: begin
                    if (key_i == KEY_GO1)
                        st_d = KS_ARM_GO;
                    else if (key_i == KEY_HALT1)
                        st_d = KS_ARM_HALT;
                end
                KS_ARM_GO: begin
                    st_d = KS_IDLE;
                    if (key_i == KEY_GO2)
                        run_d = 1'b1;
                end
                KS_ARM_HALT: begin
                    st_d = KS_IDLE;
                    if (key_i == KEY_HALT2)
                        run_d = 1'b0;
                end
                default: st_d = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= KS_IDLE;
            run_q <= 1'b0;
        end else if (sclr_i) begin
            st_q  <= KS_IDLE;
            run_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    assign run_o = run_q;

    // R2
    start_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(fire_i && key_i == KEY_GO2));

    // R3
    stop_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past((fire_i && key_i == KEY_HALT2) || sclr_i));
endmodule

// File: rtl/kwd_prescaler.sv
`timescale 1ns/1ps
module kwd_prescaler #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclr_i,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             en_i,
    input  logic [PTV_W-1:0] ptv_i,
    input  logic             restart_i,
    output logic             step_o
);
    localparam int PC_W = (1 << PTV_W) - 1;

    logic [PC_W-1:0] pc_d, pc_q, lim;

    always_comb begin
        lim    = {PC_W{1'b1}} >> (PC_W - int'(ptv_i));
        step_o = 1'b0;
        pc_d   = pc_q;
        if (run_i && tick_i) begin
            if (!en_i) begin
                step_o = 1'b1;
            end else if (pc_q == lim) begin
                step_o = 1'b1;
                pc_d   = '0;
            end else begin
                pc_d = pc_q + 1'b1;
            end
        end
        if (restart_i)
            pc_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else if (sclr_i)
            pc_q <= '0;
        else
            pc_q <= pc_d;
    end

    // R6
    step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (tick_i && run_i));
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int              CNT_W    = 32,
    parameter int              PTV_W    = 3,
    parameter int              HOLD_CYC = 3,
    parameter logic [DATA_W-1:0] REVISION = 32'h0001_0A03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              wdog_rst
);
    typedef struct packed {
        logic              srst;
        logic              pre_en;
        logic [PTV_W-1:0]  ptv;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  dly;
        logic [DATA_W-1:0] trig;
        logic [1:0]        ien;
        logic [1:0]        stat;
        logic              wdog;
    } state_t;

    state_t q, d;

    logic [N_POST-1:0] post_wr, post_busy, post_fire;
    logic [DATA_W-1:0] post_data [N_POST];
    logic              running, step, reload;
    logic [CNT_W-1:0]  cnt_inc;
    logic [1:0]        stat_set, stat_clr;

    for (genvar c = 0; c < N_POST; c++) begin : g_post
        localparam logic [ADDR_W-1:0] CH_ADDR = (c == CH_KEY) ? A_KEY : A_TRIG;
        assign post_wr[c] = wr_en && (addr == CH_ADDR);
        kwd_posted #(.DW(DATA_W), .HOLD(HOLD_CYC)) u_post (
            .clk    (clk),
            .rst_n  (rst_n),
            .sclr_i (q.srst),
            .wr_i   (post_wr[c]),
            .data_i (wdata),
            .busy_o (post_busy[c]),
            .fire_o (post_fire[c]),
            .data_o (post_data[c])
        );
    end

    kwd_keyseq u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclr_i (q.srst),
        .fire_i (post_fire[CH_KEY]),
        .key_i  (post_data[CH_KEY]),
        .run_o  (running)
    );

    assign reload = post_fire[CH_TRIG] && (post_data[CH_TRIG] != q.trig);

    kwd_prescaler #(.PTV_W(PTV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclr_i    (q.srst),
        .tick_i    (tick_en),
        .run_i     (running),
        .en_i      (q.pre_en),
        .ptv_i     (q.ptv),
        .restart_i (reload),
        .step_o    (step)
    );

    assign cnt_inc = q.cnt + 1'b1;

    always_comb begin
        d        = q;
        d.wdog   = 1'b0;
        stat_set = '0;
        stat_clr = '0;

        if (step) begin
            if (q.cnt == '1) begin
                d.cnt            = q.load;
                d.wdog           = 1'b1;
                stat_set[EV_OVF] = 1'b1;
            end else begin
                d.cnt = cnt_inc;
                if (cnt_inc == q.dly)
                    stat_set[EV_DLY] = 1'b1;
            end
        end

        if (reload) begin
            d.cnt  = q.load;
            d.trig = post_data[CH_TRIG];
        end

        if (wr_en) begin
            case (addr)
                A_SYS:  if (wdata[0]) d.srst = 1'b1;
                A_CTRL: begin
                    d.pre_en = wdata[0];
                    d.ptv    = wdata[PTV_W:1];
                end
                A_LOAD: d.load = wdata[CNT_W-1:0];
                A_DLY:  d.dly  = wdata[CNT_W-1:0];
                A_IEN:  d.ien  = q.ien | wdata[1:0];
                A_STAT: stat_clr = wdata[1:0];
                default: ;
            endcase
        end

        d.stat = (q.stat & ~stat_clr) | stat_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (q.srst)
            q <= '0;
        else
            q <= d;
    end

    always_comb begin
        case (addr)
            A_REV:   rdata = REVISION;
            A_SYS:   rdata = DATA_W'(q.srst);
            A_CTRL:  rdata = DATA_W'({q.ptv, q.pre_en});
            A_LOAD:  rdata = DATA_W'(q.load);
            A_CNT:   rdata = DATA_W'(q.cnt);
            A_TRIG:  rdata = q.trig;
            A_PEND:  rdata = DATA_W'(post_busy);
            A_DLY:   rdata = DATA_W'(q.dly);
            A_IEN:   rdata = DATA_W'(q.ien);
            A_STAT:  rdata = DATA_W'(q.stat);
            default: rdata = '0;
        endcase
    end

    assign irq      = |(q.stat & q.ien);
    assign wdog_rst = q.wdog;

    // R8
    pulse_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> q.stat[EV_OVF]);

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (q.ien != 2'b00));

    // R11
    soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst |=> (!q.srst && q.load == '0 && q.ien == 2'b00 && !running));
endmodule

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wdog_rst;

    keyed_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    int tdiv = 0;
    int tphase = 0;
    int d_pulses = 0;
    int m_pulses = 0;

    // reference model state
    logic        m_srst, m_pre, m_run, m_wd;
    int          m_ptv, m_pc, m_ks, k_left, t_left;
    logic [31:0] m_load, m_cnt, m_trig, m_dly, k_data, t_data;
    logic [1:0]  m_ien, m_stat;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mexp(input logic [3:0] a);
        case (a)
            4'd0:  return 32'h0001_0A03;
            4'd1:  return {31'b0, m_srst};
            4'd2:  return 32'(m_ptv * 2) | {31'b0, m_pre};
            4'd3:  return m_load;
            4'd4:  return m_cnt;
            4'd5:  return m_trig;
            4'd7:  return {30'b0, t_left != 0, k_left != 0};
            4'd8:  return m_dly;
            4'd9:  return {30'b0, m_ien};
            4'd10: return {30'b0, m_stat};
            default: return 32'h0;
        endcase
    endfunction

    // tick generator
    always @(negedge clk) begin
        tphase++;
        tick_en = (tdiv != 0) && (tphase % tdiv == 0);
    end

    // behavioural reference, one step per clock
    always @(posedge clk) begin
        logic [31:0] n_cnt;
        logic [1:0]  s_set, s_clr;
        int          n_pc;
        logic        tk, ok_k, ok_t;
        if (!rst_n || m_srst) begin
            m_srst = 0; m_pre = 0; m_ptv = 0; m_load = 0; m_cnt = 0; m_pc = 0;
            m_trig = 0; m_dly = 0; m_ien = 0; m_stat = 0; m_run = 0; m_ks = 0;
            m_wd = 0; k_left = 0; t_left = 0; k_data = 0; t_data = 0;
        end else begin
            tk = 0; n_cnt = m_cnt; n_pc = m_pc; s_set = 0; s_clr = 0; m_wd = 0;
            if (m_run && tick_en) begin
                if (!m_pre) tk = 1;
                else if (m_pc == (1 << m_ptv) - 1) begin tk = 1; n_pc = 0; end
                else n_pc = m_pc + 1;
            end
            if (tk) begin
                if (m_cnt == 32'hFFFF_FFFF) begin
                    n_cnt = m_load; s_set[0] = 1; m_wd = 1; m_pulses++;
                end else begin
                    n_cnt = m_cnt + 1;
                    if (n_cnt == m_dly) s_set[1] = 1;
                end
            end
            if (t_left == 1 && t_data != m_trig) begin
                n_cnt = m_load; n_pc = 0; m_trig = t_data;
            end
            if (k_left == 1) begin
                if (m_ks == 0) begin
                    if (k_data == 32'hBBBB) m_ks = 1;
                    else if (k_data == 32'hAAAA) m_ks = 2;
                end else if (m_ks == 1) begin
                    if (k_data == 32'h4444) m_run = 1;
                    m_ks = 0;
                end else begin
                    if (k_data == 32'h5555) m_run = 0;
                    m_ks = 0;
                end
            end
            ok_k = (k_left == 0);
            ok_t = (t_left == 0);
            if (k_left > 0) k_left--;
            if (t_left > 0) t_left--;
            if (wr_en) begin
                case (addr)
                    4'd1:  if (wdata[0]) m_srst = 1;
                    4'd2:  begin m_pre = wdata[0]; m_ptv = int'(wdata[3:1]); end
                    4'd3:  m_load = wdata;
                    4'd5:  if (ok_t) begin t_left = 3; t_data = wdata; end
                    4'd6:  if (ok_k) begin k_left = 3; k_data = wdata; end
                    4'd8:  m_dly = wdata;
                    4'd9:  m_ien = m_ien | wdata[1:0];
                    4'd10: s_clr = wdata[1:0];
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~s_clr) | s_set;
            m_cnt  = n_cnt;
            m_pc   = n_pc;
        end
    end

    // per-cycle comparison of the outputs
    always @(negedge clk) begin
        if (rst_n) begin
            chk({31'b0, wdog_rst}, {31'b0, m_wd}, "R8 wdog_rst per cycle");
            chk({31'b0, irq}, {31'b0, |(m_stat & m_ien)}, "R10 irq per cycle");
            if (wdog_rst) d_pulses++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        addr = a;
        #1;
        chk(rdata, mexp(a), tag);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(4'd0, "R1 revision");
        rd(4'd4, "R1 count");
        rd(4'd7, "R1 pending");
        rd(4'd3, "R1 load");
        rd(4'd10, "R1 status");
        chk({31'b0, irq}, 32'h0, "R1 irq low");
        chk({31'b0, wdog_rst}, 32'h0, "R1 wdog_rst low");

        tdiv = 1;
        wr(4'd3, 32'hFFFF_FF00);
        wr(4'd5, 32'h1); idle(4);
        rd(4'd4, "R7 changed value reloads");

        // R5 pending window
        wr(4'd6, 32'hBBBB);
        rd(4'd7, "R5 pending after write");
        chk(rdata, 32'h1, "R5 key pending bit");
        idle(1); rd(4'd7, "R5 pending second cycle");
        idle(1); rd(4'd7, "R5 pending third cycle");
        idle(1); rd(4'd7, "R5 pending cleared");
        chk(rdata, 32'h0, "R5 pending cleared literal");
        wr(4'd6, 32'h4444); idle(8);
        rd(4'd4, "R2 counter running");

        // R3 stop
        wr(4'd6, 32'hAAAA); idle(4);
        wr(4'd6, 32'h5555); idle(4);
        rd(4'd4, "R3 counter halted");
        idle(5);
        rd(4'd4, "R3 count frozen");

        // R4 malformed sequences
        wr(4'd6, 32'h4444); idle(7);
        rd(4'd4, "R4 lone second key ignored");
        wr(4'd6, 32'hBBBB); idle(4);
        wr(4'd6, 32'h1234); idle(4);
        wr(4'd6, 32'h4444); idle(6);
        rd(4'd4, "R4 broken sequence stays halted");

        // R5 write during pending dropped
        wr(4'd6, 32'hBBBB);
        wr(4'd6, 32'h4444); idle(6);
        rd(4'd4, "R5 second key while pending dropped");
        wr(4'd6, 32'h4444); idle(8);
        rd(4'd4, "R2 start after armed");

        // R7 same value no reload
        wr(4'd5, 32'h1); idle(4);
        rd(4'd4, "R7 same value no reload");

        // R8 / R9 overflow and delay
        wr(4'd8, 32'hFFFF_FFF8);
        wr(4'd9, 32'h1);
        wr(4'd3, 32'hFFFF_FFF0);
        wr(4'd5, 32'h2); idle(25);
        rd(4'd4, "R8 count after wrap");
        wr(4'd6, 32'hAAAA); idle(4);
        wr(4'd6, 32'h5555); idle(4);
        rd(4'd10, "R8 R9 status bits");
        chk(32'(d_pulses), 32'(m_pulses), "R8 pulse count");

        // R10 enables and write-1-to-clear
        wr(4'd10, 32'h1); idle(1);
        rd(4'd10, "R10 overflow bit cleared");
        wr(4'd9, 32'h2); idle(1);
        rd(4'd9, "R10 enables set");
        chk({31'b0, irq}, {31'b0, |(m_stat & m_ien)}, "R10 irq from delay");
        wr(4'd10, 32'h2); idle(1);
        rd(4'd10, "R10 delay bit cleared");

        // R6 prescaler
        wr(4'd2, 32'h5);
        rd(4'd2, "R6 control readback");
        wr(4'd6, 32'hBBBB); idle(4);
        wr(4'd6, 32'h4444); idle(16);
        rd(4'd4, "R6 divide by four");
        idle(3);
        rd(4'd4, "R6 divide by four later");
        wr(4'd2, 32'h0);
        tdiv = 3;
        idle(10);
        rd(4'd4, "R6 undivided slow ticks");

        // R11 soft reset
        wr(4'd1, 32'h1);
        rd(4'd1, "R11 reads one");
        chk(rdata, 32'h1, "R11 reads one literal");
        idle(1);
        rd(4'd1, "R11 self clears");
        rd(4'd3, "R11 load cleared");
        rd(4'd9, "R11 enables cleared");
        rd(4'd4, "R11 count cleared");
        idle(5);
        rd(4'd4, "R11 counter stopped");

        idle(2);
        report();
    end
endmodule